// File: doc/BRIEF.md
# External Memory Bus Pin Controller

This block sits between a processor's memory-cycle sequencer and the pad ring of an 8-bit external memory bus. It drives four pin groups, each as a registered value with a registered output enable: a read/write strobe, an 8-bit bidirectional data bus, a 16-bit address bus and a 6-bit extended address bus. The sequencer reports each clock whether a cycle is active, whether it starts in that clock, whether it is a read or a write, whether it is in the address or the data phase, whether it targets external or internal memory, and the level of the active-low data strobe.

A set of mode bits reshapes the pins. The strobe can act as a plain read/write level or as a write enable. Internal accesses can be hidden from the pins or shown on them. The data bus can carry the low address byte during address phases or stay data-only. A force-float bit releases every group. The strobe also floats under a global high-impedance bit or during a bus-acknowledge cycle. Pins that are hidden from an access keep their last driven value and do not float.

Top module: `ext_bus_pin_ctrl`

## Requirements
- R1: After reset rw_o is 1 with rw_oe 1, dat_oe is 0 and dat_o is 0, and adr_o and xadr_o are 0 with adr_oe and xadr_oe at 1.
- R2: With mode_we clear, a shown access with cyc_start set loads rw_o with 1 for a read (cyc_write=0) or 0 for a write (cyc_write=1). Later clocks of the same cycle leave rw_o unchanged.
- R3: With mode_we set, rw_o is 1 during every clock of a shown read and follows ds_n during every clock of a shown write.
- R4: An access is shown when cyc_active is set and either cyc_external is 1 or mode_ext_toggle is 1 with prot_active 0. An active access that is not shown leaves rw_o, dat_o and the data drive state unchanged.
- R5: With mode_ext_toggle set and prot_active clear, internal accesses update rw_o and the data bus exactly as external accesses do.
- R6: mode_float set clears rw_oe, dat_oe, adr_oe and xadr_oe. Clearing it again restores them.
- R7: glob_hiz or bus_ack clears rw_oe only. The data, address and extended address enables are unaffected.
- R8: With mode_nonmux clear, a shown access in the address phase (cyc_phase=0) sets dat_o to addr[7:0] and sets dat_oe.
- R9: With mode_nonmux set, a shown address phase clears dat_oe and leaves dat_o at its previous value.
- R10: In the data phase (cyc_phase=1), a shown write sets dat_o to wr_data and sets dat_oe. A shown read clears dat_oe.
- R11: adr_o and xadr_o load addr and xaddr on every active access, internal or external, whatever mode_nonmux, mode_ext_toggle and prot_active are. They hold while cyc_active is clear.
- R12: Every output reflects the inputs sampled at the previous rising clock edge, with exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_active | input | 1 | A memory cycle is in progress this clock |
| cyc_start | input | 1 | First clock of a memory cycle |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_phase | input | 1 | 0 = address phase, 1 = data phase |
| cyc_external | input | 1 | 1 = access targets external memory |
| ds_n | input | 1 | Active-low data strobe from the sequencer |
| wr_data | input | 8 | Write data |
| addr | input | 16 | Access address |
| xaddr | input | 6 | Extended address |
| mode_we | input | 1 | Strobe acts as write enable |
| mode_ext_toggle | input | 1 | Show internal accesses on pins |
| mode_nonmux | input | 1 | Data bus carries data only |
| mode_float | input | 1 | Release every pin group |
| prot_active | input | 1 | Internal memory protection is active |
| glob_hiz | input | 1 | Global high-impedance request for the strobe |
| bus_ack | input | 1 | Bus acknowledge cycle in progress |
| rw_o | output | 1 | Read/write strobe value |
| rw_oe | output | 1 | Read/write strobe enable |
| dat_o | output | 8 | Data bus output value |
| dat_oe | output | 1 | Data bus output enable |
| adr_o | output | 16 | Address bus value |
| adr_oe | output | 1 | Address bus enable |
| xadr_o | output | 6 | Extended address value |
| xadr_oe | output | 1 | Extended address enable |

## Verification
The bench checks that rw_o is held across the later clocks of a cycle in level mode. A design that reloads it every clock would show a read in the middle of a write. It hides internal accesses once with the toggle bit clear and once with protection active. A design that floats or updates the pins there would lose the last write data or flip the strobe. It floats only the strobe under global high-impedance and bus acknowledge, so a design that releases the whole bus under those inputs would cut off the address lines. It checks that a data-only bus keeps its last data value when it floats in an address phase, and that the address groups still follow internal accesses while the data pins are hidden.

// File: rtl/ebpc_pkg.sv
package ebpc_pkg;
   typedef enum logic {
      PH_ADDR = 1'b0,
      PH_DATA = 1'b1
   } phase_e;

   // an access reaches the pins when it is external, or internal with
   // toggling allowed and protection off
   function automatic logic shown_access(input logic active, input logic ext,
                                         input logic toggle, input logic prot);
      return active & (ext | (toggle & ~prot));
   endfunction
endpackage

// File: rtl/ebpc_strobe.sv
module ebpc_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic shown,
   input  logic cyc_start,
   input  logic cyc_write,
   input  logic ds_n,
   input  logic we_mode,
   input  logic float_req,
   output logic rw_o,
   output logic rw_oe
);
   logic rw_q, oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rw_q <= 1'b1;
         oe_q <= 1'b1;
      end else begin
         oe_q <= ~float_req;
         if (shown) begin
            if (we_mode)
               rw_q <= cyc_write ? ds_n : 1'b1;
            else if (cyc_start)
               rw_q <= ~cyc_write;
         end
      end
   end

   assign rw_o  = rw_q;
   assign rw_oe = oe_q;

   // R3
   we_read_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shown && we_mode && !cyc_write) |=> rw_o);

   // R7
   strobe_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      float_req |=> !rw_oe);
endmodule

// File: rtl/ebpc_data.sv
module ebpc_data
   import ebpc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit MUX_CAPABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shown,
   input  phase_e            phase,
   input  logic              cyc_write,
   input  logic              nonmux,
   input  logic              float_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] addr_lo,
   output logic [DATA_W-1:0] dat_o,
   output logic              dat_oe
);
   logic              drv_q, drv_d;
   logic [DATA_W-1:0] val_q, val_d;
   logic              oe_q;
   logic              addr_on_bus;

   generate
      if (MUX_CAPABLE) begin : g_mux
         assign addr_on_bus = ~nonmux;
      end else begin : g_nomux
         assign addr_on_bus = 1'b0;
      end
   endgenerate

   always_comb begin
      drv_d = drv_q;
      val_d = val_q;
      if (shown) begin
         if (phase == PH_ADDR) begin
            drv_d = addr_on_bus;
            if (addr_on_bus) val_d = addr_lo;
         end else begin
            drv_d = cyc_write;
            if (cyc_write) val_d = wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= 1'b0;
         val_q <= '0;
         oe_q  <= 1'b0;
      end else begin
         drv_q <= drv_d;
         val_q <= val_d;
         oe_q  <= drv_d & ~float_req;
      end
   end

   assign dat_o  = val_q;
   assign dat_oe = oe_q;

   // R9
   nonmux_addr_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shown && phase == PH_ADDR && nonmux) |=> (!dat_oe && $stable(dat_o)));

   // R10
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shown && phase == PH_DATA && !cyc_write) |=> !dat_oe);

   // R10
   write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shown && phase == PH_DATA && cyc_write && !float_req)
         |=> (dat_oe && dat_o == $past(wr_data)));
endmodule

// File: rtl/ebpc_addr_grp.sv
module ebpc_addr_grp #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         float_req,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_o,
   output logic         a_oe
);
   logic [W-1:0] a_q;
   logic         oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q  <= '0;
         oe_q <= 1'b1;
      end else begin
         oe_q <= ~float_req;
         if (active) a_q <= a_in;
      end
   end

   assign a_o  = a_q;
   assign a_oe = oe_q;

   // R11
   addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> a_o == $past(a_in));

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(a_o));
endmodule

// File: rtl/ext_bus_pin_ctrl.sv
module ext_bus_pin_ctrl
   import ebpc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 16,
   parameter int XADDR_W     = 6,
   parameter bit MUX_CAPABLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cyc_active,
   input  logic               cyc_start,
   input  logic               cyc_write,
   input  logic               cyc_phase,
   input  logic               cyc_external,
   input  logic               ds_n,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [XADDR_W-1:0] xaddr,
   input  logic               mode_we,
   input  logic               mode_ext_toggle,
   input  logic               mode_nonmux,
   input  logic               mode_float,
   input  logic               prot_active,
   input  logic               glob_hiz,
   input  logic               bus_ack,
   output logic               rw_o,
   output logic               rw_oe,
   output logic [DATA_W-1:0]  dat_o,
   output logic               dat_oe,
   output logic [ADDR_W-1:0]  adr_o,
   output logic               adr_oe,
   output logic [XADDR_W-1:0] xadr_o,
   output logic               xadr_oe
);
   localparam int LO_W = DATA_W;

   generate
      if (DATA_W < 1 || ADDR_W < LO_W) begin : g_bad_width
         $error("ext_bus_pin_ctrl: address narrower than data bus");
      end
      if (XADDR_W < 1) begin : g_bad_xw
         $error("ext_bus_pin_ctrl: extended address width must be positive");
      end
   endgenerate

   logic   shown;
   logic   rw_float;
   phase_e phase;

   assign shown    = shown_access(cyc_active, cyc_external, mode_ext_toggle, prot_active);
   assign rw_float = mode_float | glob_hiz | bus_ack;
   assign phase    = phase_e'(cyc_phase);

   ebpc_strobe u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .shown     (shown),
      .cyc_start (cyc_start),
      .cyc_write (cyc_write),
      .ds_n      (ds_n),
      .we_mode   (mode_we),
      .float_req (rw_float),
      .rw_o      (rw_o),
      .rw_oe     (rw_oe)
   );

   ebpc_data #(
      .DATA_W      (DATA_W),
      .MUX_CAPABLE (MUX_CAPABLE)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .shown     (shown),
      .phase     (phase),
      .cyc_write (cyc_write),
      .nonmux    (mode_nonmux),
      .float_req (mode_float),
      .wr_data   (wr_data),
      .addr_lo   (addr[LO_W-1:0]),
      .dat_o     (dat_o),
      .dat_oe    (dat_oe)
   );

   ebpc_addr_grp #(.W(ADDR_W)) u_adr (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (cyc_active),
      .float_req (mode_float),
      .a_in      (addr),
      .a_o       (adr_o),
      .a_oe      (adr_oe)
   );

   ebpc_addr_grp #(.W(XADDR_W)) u_xadr (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (cyc_active),
      .float_req (mode_float),
      .a_in      (xaddr),
      .a_o       (xadr_o),
      .a_oe      (xadr_oe)
   );

   // R6
   all_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_float |=> (!rw_oe && !dat_oe && !adr_oe && !xadr_oe));

   // R7
   hiz_addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((glob_hiz || bus_ack) && !mode_float) |=> (adr_oe && xadr_oe && !rw_oe));

   // R4
   hidden_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_active && !cyc_external && (!mode_ext_toggle || prot_active))
         |=> ($stable(rw_o) && $stable(dat_o)));

   // R2
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_we && !cyc_start) |=> $stable(rw_o));
endmodule

// File: tb/ext_bus_pin_ctrl_test.sv
`timescale 1ns/1ps
module ext_bus_pin_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_active = 0, cyc_start = 0, cyc_write = 0, cyc_phase = 0;
   logic        cyc_external = 0, ds_n = 1;
   logic [7:0]  wr_data = '0;
   logic [15:0] addr = '0;
   logic [5:0]  xaddr = '0;
   logic        mode_we = 0, mode_ext_toggle = 0, mode_nonmux = 0, mode_float = 0;
   logic        prot_active = 0, glob_hiz = 0, bus_ack = 0;
   logic        rw_o, rw_oe, dat_oe, adr_oe, xadr_oe;
   logic [7:0]  dat_o;
   logic [15:0] adr_o;
   logic [5:0]  xadr_o;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ext_bus_pin_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cyc_active(cyc_active), .cyc_start(cyc_start),
      .cyc_write(cyc_write), .cyc_phase(cyc_phase), .cyc_external(cyc_external),
      .ds_n(ds_n), .wr_data(wr_data), .addr(addr), .xaddr(xaddr),
      .mode_we(mode_we), .mode_ext_toggle(mode_ext_toggle), .mode_nonmux(mode_nonmux),
      .mode_float(mode_float), .prot_active(prot_active), .glob_hiz(glob_hiz),
      .bus_ack(bus_ack), .rw_o(rw_o), .rw_oe(rw_oe), .dat_o(dat_o), .dat_oe(dat_oe),
      .adr_o(adr_o), .adr_oe(adr_oe), .xadr_o(xadr_o), .xadr_oe(xadr_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // one clock of stimulus; outputs are sampled just after the edge that registers it
   task automatic step(input logic act, input logic st, input logic wr, input logic ph,
                       input logic ext, input logic ds, input logic [7:0] wd,
                       input logic [15:0] a, input logic [5:0] xa);
      @(negedge clk);
      cyc_active = act; cyc_start = st; cyc_write = wr; cyc_phase = ph;
      cyc_external = ext; ds_n = ds; wr_data = wd; addr = a; xaddr = xa;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 1, 8'h00, addr, xaddr);
   endtask

   task automatic t_reset();
      chk("R1 rw_o", rw_o, 1);
      chk("R1 rw_oe", rw_oe, 1);
      chk("R1 dat_oe", dat_oe, 0);
      chk("R1 dat_o", dat_o, 0);
      chk("R1 adr_o", adr_o, 0);
      chk("R1 adr_oe", adr_oe, 1);
      chk("R1 xadr_oe", xadr_oe, 1);
   endtask

   task automatic t_level_strobe();
      mode_we = 0; mode_nonmux = 1;
      step(1, 1, 1, 0, 1, 1, 8'h00, 16'h0100, 6'h01);
      chk("R2 write start", rw_o, 0);
      step(1, 0, 0, 1, 1, 0, 8'h00, 16'h0100, 6'h01);
      chk("R2 held mid cycle", rw_o, 0);
      step(1, 1, 0, 0, 1, 1, 8'h00, 16'h0102, 6'h01);
      chk("R2 read start", rw_o, 1);
      chk("R12 address one stage", adr_o, 16'h0102);
      idle();
   endtask

   task automatic t_we_strobe();
      mode_we = 1;
      step(1, 1, 1, 0, 1, 1, 8'h00, 16'h0200, 6'h02);
      chk("R3 write ds high", rw_o, 1);
      step(1, 0, 1, 1, 1, 0, 8'h11, 16'h0200, 6'h02);
      chk("R3 write ds low", rw_o, 0);
      step(1, 0, 1, 1, 1, 1, 8'h11, 16'h0200, 6'h02);
      chk("R3 write ds back high", rw_o, 1);
      step(1, 1, 0, 1, 1, 0, 8'h00, 16'h0200, 6'h02);
      chk("R3 read held high", rw_o, 1);
      mode_we = 0;
      idle();
   endtask

   task automatic t_hidden();
      mode_nonmux = 1; mode_ext_toggle = 0; prot_active = 0;
      step(1, 1, 1, 1, 1, 0, 8'hA5, 16'h0300, 6'h03);
      chk("R10 write data", dat_o, 8'hA5);
      chk("R10 write oe", dat_oe, 1);
      chk("R2 write level", rw_o, 0);
      step(1, 1, 0, 1, 0, 0, 8'h00, 16'h0304, 6'h03);
      chk("R4 toggle off rw kept", rw_o, 0);
      chk("R4 toggle off data kept", dat_o, 8'hA5);
      chk("R4 toggle off oe kept", dat_oe, 1);
      mode_ext_toggle = 1; prot_active = 1;
      step(1, 1, 0, 1, 0, 0, 8'h00, 16'h0306, 6'h03);
      chk("R4 protected rw kept", rw_o, 0);
      chk("R4 protected oe kept", dat_oe, 1);
      chk("R11 internal address", adr_o, 16'h0306);
      idle();
   endtask

   task automatic t_shown_internal();
      mode_ext_toggle = 1; prot_active = 0; mode_nonmux = 1;
      step(1, 1, 0, 1, 0, 0, 8'h00, 16'h0400, 6'h04);
      chk("R5 internal read rw", rw_o, 1);
      chk("R5 internal read oe", dat_oe, 0);
      step(1, 1, 1, 1, 0, 0, 8'h3C, 16'h0402, 6'h04);
      chk("R5 internal write data", dat_o, 8'h3C);
      chk("R5 internal write oe", dat_oe, 1);
      mode_ext_toggle = 0;
      idle();
   endtask

   task automatic t_float();
      @(negedge clk); mode_float = 1;
      idle();
      chk("R6 rw_oe", rw_oe, 0);
      chk("R6 dat_oe", dat_oe, 0);
      chk("R6 adr_oe", adr_oe, 0);
      chk("R6 xadr_oe", xadr_oe, 0);
      @(negedge clk); mode_float = 0;
      idle();
      chk("R6 rw_oe back", rw_oe, 1);
      chk("R6 adr_oe back", adr_oe, 1);
      chk("R6 dat_oe back", dat_oe, 1);
   endtask

   task automatic t_hiz_ack();
      @(negedge clk); glob_hiz = 1;
      idle();
      chk("R7 hiz rw_oe", rw_oe, 0);
      chk("R7 hiz adr_oe", adr_oe, 1);
      chk("R7 hiz xadr_oe", xadr_oe, 1);
      chk("R7 hiz dat_oe", dat_oe, 1);
      @(negedge clk); glob_hiz = 0; bus_ack = 1;
      idle();
      chk("R7 ack rw_oe", rw_oe, 0);
      chk("R7 ack adr_oe", adr_oe, 1);
      @(negedge clk); bus_ack = 0;
      idle();
      chk("R7 release", rw_oe, 1);
   endtask

   task automatic t_mux();
      mode_nonmux = 0;
      step(1, 1, 0, 0, 1, 1, 8'h00, 16'h1234, 6'h05);
      chk("R8 low byte", dat_o, 8'h34);
      chk("R8 oe", dat_oe, 1);
      step(1, 0, 0, 1, 1, 0, 8'h00, 16'h1234, 6'h05);
      chk("R10 read phase release", dat_oe, 0);
      idle();
   endtask

   task automatic t_nonmux();
      mode_nonmux = 1;
      step(1, 1, 1, 1, 1, 0, 8'h5A, 16'h5678, 6'h06);
      chk("R10 nonmux write", dat_o, 8'h5A);
      step(1, 1, 1, 0, 1, 1, 8'h00, 16'h9ABC, 6'h06);
      chk("R9 float in address", dat_oe, 0);
      chk("R9 data held", dat_o, 8'h5A);
      idle();
   endtask

   task automatic t_addr();
      mode_ext_toggle = 0; prot_active = 0; mode_nonmux = 0;
      step(1, 1, 0, 0, 0, 1, 8'h00, 16'hBEEF, 6'h2A);
      chk("R11 adr internal", adr_o, 16'hBEEF);
      chk("R11 xadr internal", xadr_o, 6'h2A);
      step(0, 0, 0, 0, 0, 1, 8'h00, 16'h1111, 6'h11);
      chk("R11 adr hold idle", adr_o, 16'hBEEF);
      chk("R11 xadr hold idle", xadr_o, 6'h2A);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk); rst_n = 1;
      t_level_strobe();
      t_we_strobe();
      t_hidden();
      t_shown_internal();
      t_float();
      t_hiz_ack();
      t_mux();
      t_nonmux();
      t_addr();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule